// File: doc/BRIEF.md
# Burst Synchronous Serial Master with CRC16

This block is a synchronous serial master that moves a whole block of bytes without help between bytes. Once started, it fetches each outgoing byte through a request/valid handshake, shifts it out on the serial data line, and returns the byte it clocked in at the same time as a one-cycle valid pulse. Each burst carries from 1 to 4096 bytes.

The serial clock is divided down from the system clock. Its idle level and the bit order within each byte are selectable. A hold request freezes the burst cleanly between two bytes, and the burst carries on when the request drops. A burst starts either from a software strobe or, when auto-start is enabled, from a falling edge on a trigger pin. A CRC16 register follows every transmitted bit in wire order and stays readable after the burst ends. A one-cycle done pulse and a sticky end flag mark the end of the burst.

Top module: `burst_sio`

## Requirements
- R1: During and straight after reset, busy, held, done, end_flag, rx_valid and byte_req are all 0.
- R2: A burst moves cfg_len+1 bytes, where cfg_len is 0 to 4095. It produces exactly cfg_len+1 rx_valid pulses, one for each byte, and then returns to idle.
- R3: When cfg_lsb_first is 1, bit 0 of each byte goes first on the wire, and the first bit received becomes bit 0 of rx_byte. When it is 0, bit 7 goes first in both directions.
- R4: While idle, sclk sits at cfg_cpol. For each bit, sdo changes on the leading edge, which is the edge away from cfg_cpol, and sdi is sampled on the trailing edge.
- R5: Each half period of sclk, from a leading edge to the following trailing edge, lasts cfg_div+1 system clock cycles.
- R6: The crc output starts at 0xFFFF when a burst starts. It is updated with every transmitted bit in wire order using the polynomial 0x1021 (x^16+x^12+x^5+1), and it holds its value after the burst.
- R7: While hold_req is high, the burst stops after the current byte completes. Held goes high and sclk stays at cfg_cpol. When hold_req drops, the burst continues with the next byte.
- R8: A falling edge on trig_n starts a burst only while cfg_auto is 1. While cfg_auto is 0, the edge is ignored and busy stays 0.
- R9: When the final byte completes, done is high for exactly one cycle and end_flag goes high. end_flag stays high until end_clr is asserted.
- R10: While byte_req is high and byte_valid is low, no sclk edge occurs. A byte is taken on a cycle where both byte_req and byte_valid are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | sclk half period minus one, in system clocks |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_len | input | LEN_W | Burst length minus one |
| cfg_auto | input | 1 | Enables starting a burst from a trig_n falling edge |
| sw_start | input | 1 | Software start strobe |
| trig_n | input | 1 | Auto-start trigger, active on a falling edge |
| hold_req | input | 1 | Request to pause at the next byte boundary |
| byte_req | output | 1 | Engine is waiting for the next transmit byte |
| byte_valid | input | 1 | byte_in holds a valid byte |
| byte_in | input | 8 | Transmit byte |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | A burst is in progress |
| held | output | 1 | Burst is paused at a byte boundary |
| done | output | 1 | One-cycle end-of-burst pulse |
| end_flag | output | 1 | Sticky end-of-burst flag |
| end_clr | input | 1 | Clears end_flag |
| crc | output | 16 | Running CRC16 |

## Verification
The assertions check on every cycle that done lasts one cycle, that end_flag holds until it is cleared, that sclk is frozen while the engine is held or waiting for a byte, that the divider never ticks on two cycles in a row when the divisor is above zero, that the CRC register is at its preset just after a start, and that the byte count stays within the programmed length. The bench scenarios cover what only end-to-end data can show. These are the bit order in both directions, the sampling and launch edges under both polarities, the exact half-period length, the CRC value, the 4096-byte boundary, a pause landing between bytes, and trigger edges being ignored when auto-start is off.

// File: rtl/sio_burst_pkg.sv
package sio_burst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_HOLD} sio_state_e;

  function automatic logic [7:0] bit_rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b,
                                            input logic [15:0] poly);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  p_half_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/sio_crc16.sv
module sio_crc16
  import sio_burst_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        bit_en,
  input  logic        bit_in,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= INIT;
    else if (init)   crc <= INIT;
    else if (bit_en) crc <= crc16_bit(crc, bit_in, POLY);
  end

  p_crc_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> crc == INIT);
endmodule

// File: rtl/sio_fall_det.sv
module sio_fall_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC-1:0], sig};
  end

  assign fall = sh[SYNC] && !sh[SYNC-1];
endmodule

// File: rtl/burst_sio.sv
module burst_sio
  import sio_burst_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_lsb_first,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_auto,
  input  logic             sw_start,
  input  logic             trig_n,
  input  logic             hold_req,
  output logic             byte_req,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             sclk,
  output logic             sdo,
  input  logic             sdi,
  output logic             busy,
  output logic             held,
  output logic             done,
  output logic             end_flag,
  input  logic             end_clr,
  output logic [15:0]      crc
);
  localparam int BIT_W = 3;

  sio_state_e       state;
  logic [LEN_W-1:0] len_q, byte_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic             lead_q;
  logic [7:0]       tx_sh, rx_sh;
  logic             tick, trig_fall, start_evt, lead_evt, trail_evt, byte_end;
  logic [7:0]       rx_nxt;

  sio_fall_det #(.SYNC(2)) u_fall (
    .clk(clk), .rst_n(rst_n), .sig(trig_n), .fall(trig_fall));

  sio_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(state == ST_SHIFT), .div(cfg_div), .tick(tick));

  assign start_evt = (state == ST_IDLE) && (sw_start || (cfg_auto && trig_fall));
  assign lead_evt  = tick && !lead_q;
  assign trail_evt = tick && lead_q;
  assign byte_end  = trail_evt && (bit_cnt == BIT_W'(7));
  assign rx_nxt    = {rx_sh[6:0], sdi};

  sio_crc16 #(.POLY(16'h1021), .INIT(16'hFFFF)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(start_evt), .bit_en(lead_evt),
    .bit_in(tx_sh[7]), .crc(crc));

  assign sclk     = cfg_cpol ^ lead_q;
  assign byte_req = (state == ST_LOAD);
  assign busy     = (state != ST_IDLE);
  assign held     = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      byte_cnt <= '0;
      bit_cnt  <= '0;
      lead_q   <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      sdo      <= 1'b0;
      done     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: if (start_evt) begin
          state    <= ST_LOAD;
          len_q    <= cfg_len;
          byte_cnt <= '0;
        end
        ST_LOAD: if (byte_valid) begin
          tx_sh   <= cfg_lsb_first ? bit_rev8(byte_in) : byte_in;
          bit_cnt <= '0;
          lead_q  <= 1'b0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (lead_evt) begin
            lead_q <= 1'b1;
            sdo    <= tx_sh[7];
          end
          if (trail_evt) begin
            lead_q  <= 1'b0;
            rx_sh   <= rx_nxt;
            tx_sh   <= {tx_sh[6:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (byte_end) begin
            rx_valid <= 1'b1;
            rx_byte  <= cfg_lsb_first ? bit_rev8(rx_nxt) : rx_nxt;
            if (byte_cnt == len_q) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              byte_cnt <= byte_cnt + 1'b1;
              state    <= hold_req ? ST_HOLD : ST_LOAD;
            end
          end
        end
        ST_HOLD: if (!hold_req) state <= ST_LOAD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       end_flag <= 1'b0;
    else if (done)    end_flag <= 1'b1;
    else if (end_clr) end_flag <= 1'b0;
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_end_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !end_clr) |=> end_flag);
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(sclk) && sclk == cfg_cpol));
  p_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && $past(byte_req) && $stable(cfg_cpol)) |-> $stable(sclk));
  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> byte_cnt <= len_q);
endmodule

// File: tb/burst_sio_test.sv
module burst_sio_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        cfg_cpol = 1'b0, cfg_lsb_first = 1'b0, cfg_auto = 1'b0;
  logic [11:0] cfg_len = '0;
  logic        sw_start = 1'b0, trig_n = 1'b1, hold_req = 1'b0, end_clr = 1'b0;
  logic        tx_gate = 1'b1;
  logic        byte_req, byte_valid, rx_valid, sclk, sdo, busy, held, done, end_flag;
  logic        sdi = 1'b0;
  logic [7:0]  byte_in, rx_byte, seed = '0;
  logic [15:0] crc;

  int n_tests = 0, n_fail = 0;
  int rx_idx = 0, tx_mis = 0, rx_mis = 0, mon_bytes = 0, mon_bits = 0, edges = 0;
  int hp_cnt = 0, hp_min = 0, hp_max = 0;
  logic       prev_sclk = 1'b0, mon_clear = 1'b0;
  logic [7:0] wire_acc = '0;

  always #5 clk = ~clk;

  burst_sio #(.LEN_W(12), .DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .cfg_auto(cfg_auto),
    .sw_start(sw_start), .trig_n(trig_n), .hold_req(hold_req),
    .byte_req(byte_req), .byte_valid(byte_valid), .byte_in(byte_in),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .busy(busy), .held(held), .done(done), .end_flag(end_flag),
    .end_clr(end_clr), .crc(crc));

  function automatic logic [7:0] tx_d(input logic [7:0] s, input int i);
    return 8'(i * 29 + int'(s) * 7 + 3);
  endfunction
  function automatic logic [7:0] sl_d(input logic [7:0] s, input int i);
    return 8'((i * 53) ^ int'(s)) + 8'd11;
  endfunction
  function automatic logic [7:0] on_wire(input logic [7:0] d, input logic lsb);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = lsb ? d[7-k] : d[k];
    return r;
  endfunction
  function automatic logic [15:0] exp_crc(input logic [7:0] s, input int nbytes,
                                          input logic lsb);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < nbytes; i++) begin
      c = c ^ {on_wire(tx_d(s, i), lsb), 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  assign byte_valid = byte_req && tx_gate;
  assign byte_in    = tx_d(seed, rx_idx);

  always @(negedge clk) begin
    if (mon_clear) begin
      rx_idx = 0; tx_mis = 0; rx_mis = 0; mon_bytes = 0; mon_bits = 0;
      edges = 0; hp_min = 9999; hp_max = 0; hp_cnt = 0;
    end else begin
      hp_cnt++;
      if (prev_sclk != cfg_cpol && sclk == cfg_cpol) begin
        edges++;
        if (hp_cnt < hp_min) hp_min = hp_cnt;
        if (hp_cnt > hp_max) hp_max = hp_cnt;
        wire_acc = {wire_acc[6:0], sdo};
        mon_bits++;
        if (mon_bits == 8) begin
          if (wire_acc != on_wire(tx_d(seed, mon_bytes), cfg_lsb_first)) tx_mis++;
          mon_bytes++;
          mon_bits = 0;
        end
      end
      if (prev_sclk == cfg_cpol && sclk != cfg_cpol) begin
        edges++;
        hp_cnt = 0;
        sdi = on_wire(sl_d(seed, mon_bytes), cfg_lsb_first)[7 - mon_bits];
      end
      if (rx_valid) begin
        if (rx_byte != sl_d(seed, rx_idx)) rx_mis++;
        rx_idx++;
      end
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clear = 1'b1;
    @(negedge clk); mon_clear = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 100000 && !seen; t++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, req, int'(seen), 1);
    if (seen) begin
      @(negedge clk);
      chk(!done, "R9 done one cycle", int'(done), 0);
      chk(end_flag, "R9 end_flag set", int'(end_flag), 1);
    end
  endtask

  task automatic check_burst(input int nb, input string req);
    chk(rx_idx == nb, req, rx_idx, nb);
    chk(mon_bytes == nb, "R2 bytes on wire", mon_bytes, nb);
    chk(tx_mis == 0, "R3 tx bits order", tx_mis, 0);
    chk(rx_mis == 0, "R3 rx bits order", rx_mis, 0);
    chk(crc == exp_crc(seed, nb, cfg_lsb_first), "R6 crc", int'(crc),
        int'(exp_crc(seed, nb, cfg_lsb_first)));
    chk(sclk == cfg_cpol && !busy, "R4 idle level", int'(sclk), int'(cfg_cpol));
    @(negedge clk); end_clr = 1'b1;
    @(negedge clk); end_clr = 1'b0;
    chk(!end_flag, "R9 end_flag cleared", int'(end_flag), 0);
  endtask

  // {len[11:0], div[7:0], cpol, lsb, seed[7:0]}
  localparam int NVEC = 5;
  localparam logic [29:0] VEC [NVEC] = '{
    {12'd0,  8'd0, 1'b0, 1'b0, 8'h1A},
    {12'd3,  8'd1, 1'b1, 1'b0, 8'h5C},
    {12'd5,  8'd2, 1'b0, 1'b1, 8'h33},
    {12'd2,  8'd0, 1'b1, 1'b1, 8'hC7},
    {12'd16, 8'd3, 1'b0, 1'b0, 8'h81}
  };

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    int e0;
    repeat (3) @(negedge clk);
    chk(!busy && !held && !done && !end_flag && !rx_valid && !byte_req,
        "R1 reset outputs", int'({busy, held, done, end_flag, rx_valid, byte_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !end_flag && !byte_req, "R1 after reset",
        int'({busy, end_flag, byte_req}), 0);

    for (int v = 0; v < NVEC; v++) begin
      cfg_len = VEC[v][29:18]; cfg_div = VEC[v][17:10];
      cfg_cpol = VEC[v][9]; cfg_lsb_first = VEC[v][8]; seed = VEC[v][7:0];
      clear_mon();
      pulse_start();
      wait_done("R2 burst done", seen);
      check_burst(int'(cfg_len) + 1, "R2 rx count");
      chk(hp_min == int'(cfg_div) + 1 && hp_max == int'(cfg_div) + 1,
          "R5 half period", hp_max, int'(cfg_div) + 1);
    end

    // R8: trigger ignored with auto-start off, honoured with it on
    cfg_len = 12'd1; cfg_div = 8'd1; cfg_cpol = 1'b1; cfg_lsb_first = 1'b0; seed = 8'h44;
    clear_mon();
    cfg_auto = 1'b0;
    @(negedge clk); trig_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && edges == 0, "R8 trigger ignored", edges, 0);
    trig_n = 1'b1;
    repeat (5) @(negedge clk);
    cfg_auto = 1'b1;
    @(negedge clk); trig_n = 1'b0;
    wait_done("R8 auto start done", seen);
    check_burst(2, "R8 auto burst count");
    trig_n = 1'b1; cfg_auto = 1'b0;
    repeat (5) @(negedge clk);

    // R7: hold at a byte boundary, then resume
    cfg_len = 12'd3; cfg_div = 8'd1; cfg_cpol = 1'b0; cfg_lsb_first = 1'b1; seed = 8'h90;
    clear_mon();
    hold_req = 1'b1;
    pulse_start();
    for (int t = 0; t < 2000 && rx_idx < 1; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    e0 = edges;
    repeat (40) @(negedge clk);
    chk(held && busy, "R7 held flag", int'(held), 1);
    chk(edges == e0 && mon_bits == 0 && mon_bytes == 1, "R7 stop at boundary",
        mon_bytes * 8 + mon_bits, 8);
    chk(sclk == cfg_cpol, "R7 sclk idle while held", int'(sclk), int'(cfg_cpol));
    hold_req = 1'b0;
    wait_done("R7 resume done", seen);
    check_burst(4, "R7 resumed count");

    // R10: no serial activity while the byte source stalls
    cfg_len = 12'd0; cfg_div = 8'd2; cfg_cpol = 1'b1; cfg_lsb_first = 1'b0; seed = 8'h0F;
    clear_mon();
    tx_gate = 1'b0;
    pulse_start();
    repeat (30) @(negedge clk);
    chk(byte_req && edges == 0, "R10 waits for byte", edges, 0);
    tx_gate = 1'b1;
    wait_done("R10 done after byte", seen);
    check_burst(1, "R10 count");

    // R2: maximum length of 4096 bytes
    cfg_len = 12'd4095; cfg_div = 8'd0; cfg_cpol = 1'b0; cfg_lsb_first = 1'b0; seed = 8'h6B;
    clear_mon();
    pulse_start();
    wait_done("R2 max burst done", seen);
    check_burst(4096, "R2 max count");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule